// File: doc/BRIEF.md
# Coin-Paid Telephone Call Controller

This block sequences a coin-paid telephone line. It watches the handset hook switch, a one-cycle coin-inserted strobe, the line status (busy, connected, fault) and a one-cycle seconds strobe that an external prescaler produces. It tells the coin mechanism when to keep or refund a coin, enables the talk path while a call is paid for, asks for another coin as a paid period nears its end, and reports when the line is out of service.

A caller lifts the handset and drops in one coin. The coin stays held until the line reports its status. A busy line followed by hanging up refunds the coin. A connected line keeps the coin and opens a paid period of `PERIOD_SEC` seconds. From second `PROMPT_SEC` of that period a prompt asks for a top-up coin. A top-up coin starts a fresh period. Without one, the call is cut when the period runs out, and the handset has to go back on the hook before a new call can begin. A line fault overrides everything and parks the controller in an out-of-service state.

Top module: `payphone_ctrl`

## Requirements
- R1: A synchronous active-high reset puts the controller in the idle state with every output at 0.
- R2: A call opens only from off-hook, a held coin and then a connected line. In the clock edge that samples the connection, coin_accept pulses for one cycle and call_en rises. A coin inserted while the handset is on the hook is refunded by a coin_return pulse in the edge that samples it.
- R3: A coin held while the line reports busy is refunded by exactly one coin_return pulse in the edge that samples the handset back on the hook. When busy and connected are reported together, busy takes precedence.
- R4: While a call is connected, the seconds counter advances only on a sec_tick strobe, and cycles without a tick do not advance it. call_en falls in the edge that samples the PERIOD_SEC-th tick of the current period.
- R5: topup_prompt is 1 from the edge that samples the PROMPT_SEC-th tick of a period until the period ends or a top-up coin is accepted, and it is never 1 while call_en is 0.
- R6: A coin inserted while topup_prompt is 1 produces a one-cycle coin_accept pulse, clears the prompt and starts a full new period. If such a coin arrives in the same cycle as the final tick, the coin takes precedence.
- R7: A coin inserted during a connected call before the prompt is refunded by a coin_return pulse and does not extend the call.
- R8: After a call times out, coins are refunded and line status is ignored until the handset has been back on the hook. After that, a new call can be made in the normal way.
- R9: line_fault sampled in any state puts out_of_order at 1 and call_en at 0 in the same edge, without a coin_accept.
- R10: out_of_order falls only in an edge that samples line_fault at 0 and the handset on the hook. A coin held when the fault arrived is refunded by a single coin_return pulse in that edge, and there is no refund when no coin was held.
- R11: Hanging up during a connected call drops call_en in the next edge and produces no coin pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| off_hook | input | 1 | Hook switch, 1 when the handset is lifted |
| coin_in | input | 1 | One-cycle strobe for each coin inserted |
| line_busy | input | 1 | Line reports the called party busy |
| line_conn | input | 1 | Line reports the call connected |
| line_fault | input | 1 | Line reports a fault |
| sec_tick | input | 1 | One-cycle strobe once per second |
| coin_return | output | 1 | One-cycle pulse that refunds a coin |
| coin_accept | output | 1 | One-cycle pulse that keeps a coin |
| call_en | output | 1 | Talk path enable (level) |
| topup_prompt | output | 1 | Request for another coin (level) |
| out_of_order | output | 1 | Line out of service (level) |

## Verification
The bench builds the controller with its default parameters: a 60-second period, a prompt at second 45 and a 6-bit counter. Because sec_tick is an ordinary input, the bench can pulse it in consecutive cycles. This walks through complete paid periods, the cycle before the prompt, the cycle before timeout and a top-up in the middle of the prompt window within a few hundred clocks. Idle cycles without a tick are mixed in to show that the counter advances only on the strobe.

// File: rtl/payphone_pkg.sv
package payphone_pkg;

  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_NEED_COIN = 3'd1,
    ST_COIN_HELD = 3'd2,
    ST_BUSY      = 3'd3,
    ST_TALK      = 3'd4,
    ST_ENDED     = 3'd5,
    ST_FAULT     = 3'd6
  } call_st_t;

endpackage

// File: rtl/pp_sec_counter.sv
module pp_sec_counter #(
  parameter int PERIOD_SEC = 60,
  parameter int PROMPT_SEC = 45,
  localparam int CNT_W = $clog2(PERIOD_SEC)
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic inc,
  output logic at_last,
  output logic in_zone,
  output logic zone_nxt
);

  localparam logic [CNT_W-1:0] LAST_V   = CNT_W'(PERIOD_SEC - 1);
  localparam logic [CNT_W-1:0] PROMPT_V = CNT_W'(PROMPT_SEC);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  always_comb begin
    if (clr)      cnt_d = '0;
    else if (inc) cnt_d = cnt_q + 1'b1;
    else          cnt_d = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_d;
  end

  assign at_last  = (cnt_q == LAST_V);
  assign in_zone  = (cnt_q >= PROMPT_V);
  assign zone_nxt = (cnt_d >= PROMPT_V);

  // R4
  cnt_range_chk: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= LAST_V)
    else $error("seconds counter beyond period");

endmodule

// File: rtl/pp_call_fsm.sv
module pp_call_fsm
  import payphone_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic off_hook,
  input  logic coin_in,
  input  logic line_busy,
  input  logic line_conn,
  input  logic line_fault,
  input  logic sec_tick,
  input  logic at_last,
  input  logic in_zone,
  output logic nxt_talk,
  output logic nxt_fault,
  output logic cnt_clr,
  output logic cnt_inc,
  output logic ret_ev,
  output logic acc_ev
);

  call_st_t state_q, nxt;
  logic     held_q, held_d;
  logic     topup;

  always_comb begin
    nxt    = state_q;
    held_d = held_q;
    ret_ev = 1'b0;
    acc_ev = 1'b0;
    topup  = 1'b0;
    if (line_fault) begin
      nxt    = ST_FAULT;
      ret_ev = coin_in;
      if (state_q != ST_FAULT)
        held_d = (state_q == ST_COIN_HELD) || (state_q == ST_BUSY);
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          ret_ev = coin_in;
          if (off_hook) nxt = ST_NEED_COIN;
        end
        ST_NEED_COIN: begin
          if (!off_hook) begin
            nxt    = ST_IDLE;
            ret_ev = coin_in;
          end else if (coin_in) begin
            nxt = ST_COIN_HELD;
          end
        end
        ST_COIN_HELD: begin
          if (!off_hook) begin
            nxt    = ST_IDLE;
            ret_ev = 1'b1;
          end else begin
            ret_ev = coin_in;
            if (line_busy) nxt = ST_BUSY;
            else if (line_conn) begin
              nxt    = ST_TALK;
              acc_ev = 1'b1;
            end
          end
        end
        ST_BUSY: begin
          if (!off_hook) begin
            nxt    = ST_IDLE;
            ret_ev = 1'b1;
          end else begin
            ret_ev = coin_in;
          end
        end
        ST_TALK: begin
          if (!off_hook) begin
            nxt    = ST_IDLE;
            ret_ev = coin_in;
          end else if (coin_in) begin
            if (in_zone) begin
              acc_ev = 1'b1;
              topup  = 1'b1;
            end else begin
              ret_ev = 1'b1;
            end
          end else if (sec_tick && at_last) begin
            nxt = ST_ENDED;
          end
        end
        ST_ENDED: begin
          ret_ev = coin_in;
          if (!off_hook) nxt = ST_IDLE;
        end
        ST_FAULT: begin
          ret_ev = coin_in;
          if (!off_hook) begin
            nxt    = ST_IDLE;
            ret_ev = coin_in || held_q;
            held_d = 1'b0;
          end
        end
        default: nxt = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      held_q  <= 1'b0;
    end else begin
      state_q <= nxt;
      held_q  <= held_d;
    end
  end

  assign nxt_talk  = (nxt == ST_TALK);
  assign nxt_fault = (nxt == ST_FAULT);
  assign cnt_clr   = (state_q != ST_TALK) || (nxt != ST_TALK) || topup;
  assign cnt_inc   = sec_tick;

  // R9
  fault_entry_chk: assert property (@(posedge clk) disable iff (rst)
    line_fault |=> (state_q == ST_FAULT))
    else $error("fault did not force out-of-service state");

endmodule

// File: rtl/pp_out_reg.sv
module pp_out_reg (
  input  logic clk,
  input  logic rst,
  input  logic nxt_talk,
  input  logic nxt_fault,
  input  logic zone_nxt,
  input  logic ret_ev,
  input  logic acc_ev,
  output logic coin_return,
  output logic coin_accept,
  output logic call_en,
  output logic topup_prompt,
  output logic out_of_order
);

  always_ff @(posedge clk) begin
    if (rst) begin
      coin_return  <= 1'b0;
      coin_accept  <= 1'b0;
      call_en      <= 1'b0;
      topup_prompt <= 1'b0;
      out_of_order <= 1'b0;
    end else begin
      coin_return  <= ret_ev;
      coin_accept  <= acc_ev;
      call_en      <= nxt_talk;
      topup_prompt <= nxt_talk && zone_nxt;
      out_of_order <= nxt_fault;
    end
  end

  // R5
  prompt_in_call_chk: assert property (@(posedge clk) disable iff (rst)
    topup_prompt |-> call_en)
    else $error("prompt without a call");

  // R2
  call_start_paid_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(call_en) |-> coin_accept)
    else $error("call opened without taking a coin");

  // R9
  fault_no_call_chk: assert property (@(posedge clk) disable iff (rst)
    !(out_of_order && (call_en || coin_accept)))
    else $error("call active while out of service");

endmodule

// File: rtl/payphone_ctrl.sv
module payphone_ctrl #(
  parameter int PERIOD_SEC = 60,
  parameter int PROMPT_SEC = 45
) (
  input  logic clk,
  input  logic rst,
  input  logic off_hook,
  input  logic coin_in,
  input  logic line_busy,
  input  logic line_conn,
  input  logic line_fault,
  input  logic sec_tick,
  output logic coin_return,
  output logic coin_accept,
  output logic call_en,
  output logic topup_prompt,
  output logic out_of_order
);

  logic at_last, in_zone, zone_nxt;
  logic nxt_talk, nxt_fault, cnt_clr, cnt_inc, ret_ev, acc_ev;

  pp_sec_counter #(.PERIOD_SEC(PERIOD_SEC), .PROMPT_SEC(PROMPT_SEC)) u_cnt (
    .clk(clk), .rst(rst), .clr(cnt_clr), .inc(cnt_inc),
    .at_last(at_last), .in_zone(in_zone), .zone_nxt(zone_nxt)
  );

  pp_call_fsm u_fsm (
    .clk(clk), .rst(rst), .off_hook(off_hook), .coin_in(coin_in),
    .line_busy(line_busy), .line_conn(line_conn), .line_fault(line_fault),
    .sec_tick(sec_tick), .at_last(at_last), .in_zone(in_zone),
    .nxt_talk(nxt_talk), .nxt_fault(nxt_fault), .cnt_clr(cnt_clr),
    .cnt_inc(cnt_inc), .ret_ev(ret_ev), .acc_ev(acc_ev)
  );

  pp_out_reg u_out (
    .clk(clk), .rst(rst), .nxt_talk(nxt_talk), .nxt_fault(nxt_fault),
    .zone_nxt(zone_nxt), .ret_ev(ret_ev), .acc_ev(acc_ev),
    .coin_return(coin_return), .coin_accept(coin_accept), .call_en(call_en),
    .topup_prompt(topup_prompt), .out_of_order(out_of_order)
  );

  // R10
  fault_exit_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(out_of_order) |-> $past(!line_fault && !off_hook))
    else $error("left out-of-service state too early");

endmodule

// File: tb/test_payphone_ctrl.sv
module test_payphone_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 14;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic off_hook = 1'b0, coin_in = 1'b0, line_busy = 1'b0;
  logic line_conn = 1'b0, line_fault = 1'b0, sec_tick = 1'b0;
  logic coin_return, coin_accept, call_en, topup_prompt, out_of_order;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  payphone_ctrl i_payphone_ctrl (
    .clk(clk), .rst(rst), .off_hook(off_hook), .coin_in(coin_in),
    .line_busy(line_busy), .line_conn(line_conn), .line_fault(line_fault),
    .sec_tick(sec_tick), .coin_return(coin_return), .coin_accept(coin_accept),
    .call_en(call_en), .topup_prompt(topup_prompt), .out_of_order(out_of_order)
  );

  // entry: {req[3:0], inputs {hook,coin,busy,conn,fault,tick}, expected {ret,acc,en,prompt,ooo}}
  localparam logic [14:0] VEC [NVEC] = '{
    {4'd2,  6'b010000, 5'b10000},  // R2 coin on hook refunded
    {4'd2,  6'b100000, 5'b00000},  // R2 lift
    {4'd2,  6'b110000, 5'b00000},  // R2 coin held
    {4'd3,  6'b101100, 5'b00000},  // R3 busy wins over connect
    {4'd3,  6'b000000, 5'b10000},  // R3 hang up refunds
    {4'd3,  6'b000000, 5'b00000},  // R3 single pulse
    {4'd2,  6'b100000, 5'b00000},  // R2 lift
    {4'd2,  6'b110000, 5'b00000},  // R2 coin held
    {4'd2,  6'b100100, 5'b01100},  // R2 connect: accept, call on
    {4'd2,  6'b100100, 5'b00100},  // R2 call stays on
    {4'd7,  6'b110000, 5'b10100},  // R7 early coin refunded
    {4'd7,  6'b100001, 5'b00100},  // R7 no extension
    {4'd11, 6'b000000, 5'b00000},  // R11 hang up ends call
    {4'd11, 6'b000000, 5'b00000}   // R11 no pulses
  };

  task automatic drv(input logic [5:0] v);
    {off_hook, coin_in, line_busy, line_conn, line_fault, sec_tick} = v;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input int req, input logic [4:0] exp);
    logic [4:0] act;
    act = {coin_return, coin_accept, call_en, topup_prompt, out_of_order};
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic open_call();
    drv(6'b100000);
    drv(6'b110000);
    drv(6'b100100);
    chk(2, 5'b01100); // R2
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(1, 5'b00000); // R1 during reset
    rst = 1'b0;
    drv(6'b000000);
    chk(1, 5'b00000); // R1 idle after reset

    for (int i = 0; i < NVEC; i++) begin
      drv(VEC[i][10:5]);
      chk(int'(VEC[i][14:11]), VEC[i][4:0]);
    end

    // R4 / R5: full period, ticks only counted when strobed
    open_call();
    repeat (10) drv(6'b100000);
    repeat (44) drv(6'b100001);
    chk(5, 5'b00100);  // R5 not yet prompting at 44
    drv(6'b100001);
    chk(5, 5'b00110);  // R5 prompt at 45
    repeat (14) drv(6'b100001);
    chk(4, 5'b00110);  // R4 still on at 59
    drv(6'b100001);
    chk(4, 5'b00000);  // R4 off at 60
    // R8: ended, waits for hang up
    drv(6'b110000);
    chk(8, 5'b10000);  // R8 coin refunded
    drv(6'b100100);
    chk(8, 5'b00000);  // R8 connect ignored
    drv(6'b000000);
    chk(8, 5'b00000);
    open_call();       // R8 new call possible

    // R6: top-up inside prompt window
    repeat (50) drv(6'b100001);
    chk(6, 5'b00110);
    drv(6'b110000);
    chk(6, 5'b01100);  // R6 accepted, prompt cleared
    repeat (59) drv(6'b100001);
    chk(6, 5'b00110);  // R6 full new period
    drv(6'b110001);
    chk(6, 5'b01100);  // R6 coin beats final tick
    repeat (60) drv(6'b100001);
    chk(6, 5'b00000);
    drv(6'b000000);

    // R9 / R10: fault during a call
    open_call();
    drv(6'b100010);
    chk(9, 5'b00001);  // R9
    drv(6'b000010);
    chk(10, 5'b00001); // R10 fault still present
    drv(6'b100000);
    chk(10, 5'b00001); // R10 handset still lifted
    drv(6'b000000);
    chk(10, 5'b00000); // R10 leave, no refund

    // R10: fault with coin held
    drv(6'b100000);
    drv(6'b110000);
    drv(6'b100010);
    chk(9, 5'b00001);  // R9
    drv(6'b000000);
    chk(10, 5'b10000); // R10 held coin refunded
    drv(6'b000000);
    chk(10, 5'b00000); // R10 single pulse

    // R9: fault from idle with a coin
    drv(6'b010010);
    chk(9, 5'b10001);
    drv(6'b000000);
    chk(10, 5'b00000);

    // R1: reset in mid-call
    open_call();
    rst = 1'b1;
    drv(6'b100000);
    chk(1, 5'b00000);
    rst = 1'b0;
    drv(6'b100100);
    chk(1, 5'b00000);  // R1 back in idle: connect ignored
    drv(6'b000000);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule